// File: doc/BRIEF.md
# Snooping MOESI Cache Line Controller

This block holds the coherence state of each line of a small private cache that sits on a shared snooping bus. A direct-mapped array keeps one tag and one coherence state per entry. The processor side presents reads and writes. The controller decides whether each access hits or needs a bus transaction: a read for a shared copy, a read-for-ownership, or an upgrade. It also reports a dirty victim that must be written back when a miss replaces it.

On the bus side the controller watches the transactions of other caches. For a snooped transaction that matches a resident line it supplies data (flush from a dirty or owning copy, optional flush from a clean exclusive copy), asserts the shared wire for snooped reads, and downgrades or invalidates the line. A snoop and a processor request cannot both act in one cycle. The snoop wins, and the processor sees a stall.

A parameter picks the protocol family. The full five-state variant allows dirty sharing through an owned state. The four-state variant has no owned state, so a dirty line that is read by another cache is written to memory and becomes shared. The three-state variant also drops the clean-exclusive state.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every entry is invalid: `cpu_line_state` reports 0 for every address. The state encoding is I=0, S=1, E=2, O=3, M=4.
- R2: A processor read to a line in I drives `bus_op`=1 (read shared), with `bus_op` encoded none=0, read=1, read-exclusive=2, upgrade=3. The line then holds E if `bus_shared_in` was low and S if it was high. In the three-state mode it always holds S.
- R3: A processor read to a line in M, O, E or S gives `cpu_hit`=1 and `bus_op`=0, and leaves the state unchanged.
- R4: A processor write always leaves the line in M. From M or E it issues nothing. From S or O it issues upgrade (3). From I it issues read-exclusive (2).
- R5: A snooped read (`snoop_op`=1) to a line in M asserts `snoop_flush`. In the five-state mode the line moves to O with `snoop_mem_update`=0. In the other modes the line moves to S with `snoop_mem_update`=1.
- R6: A snooped read to a line in O flushes and keeps O. To a line in E it asserts `snoop_flush_opt` and moves to S. To a line in S it supplies no data and stays S.
- R7: A snooped read-exclusive (`snoop_op`=2) invalidates a valid line. It flushes from M or O, flush-optionals from E, and supplies no data from S.
- R8: A snooped upgrade (`snoop_op`=3) invalidates a valid line and supplies no data.
- R9: A snoop to a line in I, or to an address whose tag differs from the resident tag, drives no flush, flush-optional, memory update or shared response, and leaves the resident line unchanged.
- R10: `snoop_shared_out` is high for a snooped read exactly when the line is held in M, O, E or S.
- R11: A processor miss that displaces a resident line in M or O asserts `wb_valid` with the old tag on `wb_tag`. Displacing a line in E or S raises no write-back.
- R12: While `snoop_valid` is high, `cpu_ready` is 0, the processor request issues no bus operation, reports no hit and changes no state.
- R13: The four-state mode never holds a line in O, and the three-state mode never holds a line in E or O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | Request is a write (else read) |
| cpu_addr | input | TAG_W+log2(NLINES) | Line address: tag above, index below |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_hit | output | 1 | Addressed line is valid for the accepted request |
| cpu_line_state | output | 3 | Current state of the line at `cpu_addr` |
| bus_op | output | 2 | Bus transaction issued for the request |
| bus_shared_in | input | 1 | Shared wire sampled during a read miss |
| wb_valid | output | 1 | Dirty victim must be written back |
| wb_tag | output | TAG_W | Tag of the displaced victim |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_op | input | 2 | Snooped transaction kind |
| snoop_addr | input | TAG_W+log2(NLINES) | Snooped line address |
| snoop_flush | output | 1 | Supply data from a dirty or owning copy |
| snoop_flush_opt | output | 1 | Supply data from a clean exclusive copy |
| snoop_mem_update | output | 1 | Flushed data must also update memory |
| snoop_shared_out | output | 1 | This cache holds the snooped line |

## Verification
The bench walks every reachable starting state in all three modes through every processor and snoop operation, with the shared wire both low and high. This catches a design that keeps E after a shared read miss, or one that upgrades E to M through the bus instead of silently. It looks for a dirty line that is read by another cache and then drops its ownership or skips the memory update in the wrong mode. A controller that leaves an owned state behind in the four-state mode would break R13 on the very next step. Further directed sequences cover tag-mismatched snoops that must not touch the resident line, victims in every state (only M and O may raise a write-back), and a snoop colliding with a processor write, where a missing stall would let the write slip through.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_RDX  = 2'd2,
        OP_UPG  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        PROTO_MSI   = 2'd0,
        PROTO_MESI  = 2'd1,
        PROTO_MOESI = 2'd2
    } proto_e;

    typedef struct packed {
        bus_op_e     op;
        logic        hit;
        line_state_e nxt;
    } proc_res_t;

    typedef struct packed {
        logic        flush;
        logic        flush_opt;
        logic        mem_upd;
        logic        shared;
        line_state_e nxt;
    } snoop_res_t;

    function automatic logic is_dirty(line_state_e st);
        return (st == ST_M) || (st == ST_O);
    endfunction

    function automatic logic is_valid(line_state_e st);
        return st != ST_I;
    endfunction

endpackage

// File: rtl/coh_tag_array.sv
module coh_tag_array
    import coh_pkg::*;
#(
    parameter int     NLINES = 4,
    parameter int     TAG_W  = 2,
    parameter proto_e PROTO  = PROTO_MOESI,
    localparam int    IDX_W  = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output line_state_e       a_st,
    output logic [TAG_W-1:0]  a_tag,
    input  logic [IDX_W-1:0]  b_idx,
    output line_state_e       b_st,
    output logic [TAG_W-1:0]  b_tag,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  line_state_e       w_st,
    input  logic [TAG_W-1:0]  w_tag
);

    line_state_e      st_q  [NLINES];
    logic [TAG_W-1:0] tag_q [NLINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINES; i++) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
            end
        end else if (we) begin
            st_q[w_idx]  <= w_st;
            tag_q[w_idx] <= w_tag;
        end
    end

    assign a_st  = st_q[a_idx];
    assign a_tag = tag_q[a_idx];
    assign b_st  = st_q[b_idx];
    assign b_tag = tag_q[b_idx];

    for (genvar g = 0; g < NLINES; g++) begin : g_line_chk
        // R13: reduced protocols never hold the states they lack
        assert_mode_states_R13: assert property (@(posedge clk) disable iff (rst)
            !(((PROTO != PROTO_MOESI) && (st_q[g] == ST_O)) ||
              ((PROTO == PROTO_MSI) && (st_q[g] == ST_E))))
            else $error("R13: illegal state %0d in line %0d", st_q[g], g);
    end

endmodule

// File: rtl/coh_proc_ctrl.sv
module coh_proc_ctrl
    import coh_pkg::*;
#(
    parameter proto_e PROTO = PROTO_MOESI
) (
    input  line_state_e cur,
    input  logic        is_write,
    input  logic        shared_in,
    output proc_res_t   res
);

    line_state_e fill_st;

    if (PROTO == PROTO_MSI) begin : g_no_excl
        assign fill_st = ST_S;
    end else begin : g_excl
        assign fill_st = shared_in ? ST_S : ST_E;
    end

    always_comb begin
        res.op  = OP_NONE;
        res.hit = is_valid(cur);
        res.nxt = cur;
        if (is_write) begin
            res.nxt = ST_M;
            case (cur)
                ST_I:       res.op = OP_RDX;
                ST_S, ST_O: res.op = OP_UPG;
                default:    res.op = OP_NONE;
            endcase
        end else if (cur == ST_I) begin
            res.op  = OP_RD;
            res.nxt = fill_st;
        end
    end

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
    import coh_pkg::*;
#(
    parameter proto_e PROTO = PROTO_MOESI
) (
    input  logic        valid,
    input  bus_op_e     op,
    input  line_state_e cur,
    output snoop_res_t  res
);

    line_state_e dirty_rd_nxt;
    logic        dirty_rd_mem;

    if (PROTO == PROTO_MOESI) begin : g_owned
        assign dirty_rd_nxt = ST_O;
        assign dirty_rd_mem = 1'b0;
    end else begin : g_clean_share
        assign dirty_rd_nxt = ST_S;
        assign dirty_rd_mem = 1'b1;
    end

    always_comb begin
        res.flush     = 1'b0;
        res.flush_opt = 1'b0;
        res.mem_upd   = 1'b0;
        res.shared    = 1'b0;
        res.nxt       = cur;
        if (valid && is_valid(cur)) begin
            case (op)
                OP_RD: begin
                    res.shared = 1'b1;
                    case (cur)
                        ST_M: begin
                            res.flush   = 1'b1;
                            res.nxt     = dirty_rd_nxt;
                            res.mem_upd = dirty_rd_mem;
                        end
                        ST_O: res.flush = 1'b1;
                        ST_E: begin
                            res.flush_opt = 1'b1;
                            res.nxt       = ST_S;
                        end
                        default: res.nxt = cur;
                    endcase
                end
                OP_RDX: begin
                    res.flush     = is_dirty(cur);
                    res.flush_opt = (cur == ST_E);
                    res.nxt       = ST_I;
                end
                OP_UPG:  res.nxt = ST_I;
                default: res.nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import coh_pkg::*;
#(
    parameter int     NLINES = 4,
    parameter int     TAG_W  = 2,
    parameter proto_e PROTO  = PROTO_MOESI,
    localparam int    IDX_W  = $clog2(NLINES),
    localparam int    ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [2:0]        cpu_line_state,
    output logic [1:0]        bus_op,
    input  logic              bus_shared_in,
    output logic              wb_valid,
    output logic [TAG_W-1:0]  wb_tag,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_op,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_flush,
    output logic              snoop_flush_opt,
    output logic              snoop_mem_update,
    output logic              snoop_shared_out
);

    logic [IDX_W-1:0] cpu_idx, snp_idx, w_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag, a_tag, b_tag, w_tag;
    line_state_e      a_st, b_st, cpu_cur, snp_cur, w_st;
    logic             cpu_go, we;
    proc_res_t        pres;
    snoop_res_t       sres;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snoop_addr[IDX_W-1:0];
    assign snp_tag = snoop_addr[ADDR_W-1:IDX_W];

    coh_tag_array #(.NLINES(NLINES), .TAG_W(TAG_W), .PROTO(PROTO)) u_array (
        .clk   (clk),
        .rst   (rst),
        .a_idx (cpu_idx),
        .a_st  (a_st),
        .a_tag (a_tag),
        .b_idx (snp_idx),
        .b_st  (b_st),
        .b_tag (b_tag),
        .we    (we),
        .w_idx (w_idx),
        .w_st  (w_st),
        .w_tag (w_tag)
    );

    assign cpu_cur = (a_tag == cpu_tag) ? a_st : ST_I;
    assign snp_cur = (b_tag == snp_tag) ? b_st : ST_I;

    coh_proc_ctrl #(.PROTO(PROTO)) u_proc (
        .cur       (cpu_cur),
        .is_write  (cpu_write),
        .shared_in (bus_shared_in),
        .res       (pres)
    );

    coh_snoop_ctrl #(.PROTO(PROTO)) u_snoop (
        .valid (snoop_valid),
        .op    (bus_op_e'(snoop_op)),
        .cur   (snp_cur),
        .res   (sres)
    );

    // snoops own the bus cycle; the processor waits
    assign cpu_ready      = !snoop_valid;
    assign cpu_go         = cpu_valid && cpu_ready;
    assign cpu_hit        = cpu_go && pres.hit;
    assign bus_op         = cpu_go ? pres.op : OP_NONE;
    assign cpu_line_state = cpu_cur;
    assign wb_valid       = cpu_go && (a_tag != cpu_tag) && is_dirty(a_st);
    assign wb_tag         = a_tag;

    assign snoop_flush      = sres.flush;
    assign snoop_flush_opt  = sres.flush_opt;
    assign snoop_mem_update = sres.mem_upd;
    assign snoop_shared_out = sres.shared;

    always_comb begin
        we    = 1'b0;
        w_idx = cpu_idx;
        w_st  = pres.nxt;
        w_tag = cpu_tag;
        if (snoop_valid) begin
            if (is_valid(snp_cur)) begin
                we    = 1'b1;
                w_idx = snp_idx;
                w_st  = sres.nxt;
                w_tag = b_tag;
            end
        end else if (cpu_valid) begin
            we = 1'b1;
        end
    end

    // R12: a colliding snoop blocks the processor request entirely
    assert_cpu_stall_R12: assert property (@(posedge clk) disable iff (rst)
        snoop_valid |-> (!cpu_ready && !cpu_hit && (bus_op == OP_NONE) && !wb_valid))
        else $error("R12: processor acted during snoop");

    // R4: an accepted write leaves the line in M on the following cycle
    assert_write_to_m_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_go && cpu_write) ##1 (cpu_addr == $past(cpu_addr)) |-> (cpu_cur == ST_M))
        else $error("R4: line not M after write");

    // R3: a read hit uses no bus and evicts nothing
    assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_hit && !cpu_write) |-> ((bus_op == OP_NONE) && !wb_valid))
        else $error("R3: read hit touched the bus");

    // R9: absent lines give no snoop response
    assert_snoop_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && (snp_cur == ST_I)) |->
        !(snoop_flush || snoop_flush_opt || snoop_mem_update || snoop_shared_out))
        else $error("R9: response from an absent line");

    // R7: data supply comes from one source only
    assert_flush_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(snoop_flush && snoop_flush_opt))
        else $error("R7: flush and flush-optional together");

    // R7, R8: invalidating snoops leave the line invalid
    assert_snoop_inval_R8: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && (snoop_op != OP_RD) && (snoop_op != OP_NONE)) ##1
        (snoop_addr == $past(snoop_addr)) |-> (snp_cur == ST_I))
        else $error("R8: line survived an invalidating snoop");

endmodule

// File: tb/tb_moesi_line_ctrl.sv
module tb_moesi_line_ctrl;
    import coh_pkg::*;

    localparam int NM = 3;
    localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       cpu_valid [NM];
    logic       cpu_write [NM];
    logic [3:0] cpu_addr  [NM];
    logic       shared_in [NM];
    logic       snoop_valid [NM];
    logic [1:0] snoop_op  [NM];
    logic [3:0] snoop_addr [NM];
    logic       ready_o [NM];
    logic       hit_o   [NM];
    logic [2:0] lst_o   [NM];
    logic [1:0] op_o    [NM];
    logic       wb_o    [NM];
    logic [1:0] wbt_o   [NM];
    logic       fl_o    [NM];
    logic       fo_o    [NM];
    logic       mu_o    [NM];
    logic       sh_o    [NM];

    for (genvar m = 0; m < NM; m++) begin : g_mode
        moesi_line_ctrl #(.NLINES(4), .TAG_W(2), .PROTO(proto_e'(m))) dut (
            .clk              (clk),
            .rst              (rst),
            .cpu_valid        (cpu_valid[m]),
            .cpu_write        (cpu_write[m]),
            .cpu_addr         (cpu_addr[m]),
            .cpu_ready        (ready_o[m]),
            .cpu_hit          (hit_o[m]),
            .cpu_line_state   (lst_o[m]),
            .bus_op           (op_o[m]),
            .bus_shared_in    (shared_in[m]),
            .wb_valid         (wb_o[m]),
            .wb_tag           (wbt_o[m]),
            .snoop_valid      (snoop_valid[m]),
            .snoop_op         (snoop_op[m]),
            .snoop_addr       (snoop_addr[m]),
            .snoop_flush      (fl_o[m]),
            .snoop_flush_opt  (fo_o[m]),
            .snoop_mem_update (mu_o[m]),
            .snoop_shared_out (sh_o[m])
        );
    end

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int g_ready, g_hit, g_op, g_wb, g_wbt, g_fl, g_fo, g_mu, g_sh;

    typedef struct packed {
        int op; int hit; int fl; int fo; int mu; int sh; int nx;
    } exp_t;

    task automatic chk(input string req, input string what, input int got, input int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    task automatic drive(input int m, input bit cv, input bit cw, input int ca, input bit sh,
                         input bit sv, input int so, input int sa);
        @(negedge clk);
        cpu_valid[m]   = cv;
        cpu_write[m]   = cw;
        cpu_addr[m]    = 4'(ca);
        shared_in[m]   = sh;
        snoop_valid[m] = sv;
        snoop_op[m]    = 2'(so);
        snoop_addr[m]  = 4'(sa);
        #2;
        g_ready = int'(ready_o[m]);
        g_hit   = int'(hit_o[m]);
        g_op    = int'(op_o[m]);
        g_wb    = int'(wb_o[m]);
        g_wbt   = int'(wbt_o[m]);
        g_fl    = int'(fl_o[m]);
        g_fo    = int'(fo_o[m]);
        g_mu    = int'(mu_o[m]);
        g_sh    = int'(sh_o[m]);
        @(posedge clk);
        #1;
        cpu_valid[m]   = 1'b0;
        snoop_valid[m] = 1'b0;
    endtask

    // kind: 0 cpu read, 1 cpu write, 2 snoop read, 3 snoop read-exclusive, 4 snoop upgrade
    task automatic do_op(input int m, input int kind, input bit sh, input int addr);
        if (kind < 2) drive(m, 1'b1, kind == 1, addr, sh, 1'b0, 0, 0);
        else          drive(m, 1'b0, 1'b0, 0, sh, 1'b1, kind - 1, addr);
    endtask

    task automatic probe(input int m, input int addr, output int st);
        @(negedge clk);
        cpu_valid[m] = 1'b0;
        cpu_addr[m]  = 4'(addr);
        #2;
        st = int'(lst_o[m]);
    endtask

    function automatic exp_t model(input int m, input int st, input int kind, input bit sh);
        exp_t e;
        e = '{op: 0, hit: 0, fl: 0, fo: 0, mu: 0, sh: 0, nx: st};
        case (kind)
            0: if (st == SI) begin
                   e.op = 1;
                   e.nx = (m == 0 || sh) ? SS : SE;
               end else e.hit = 1;
            1: begin
                   e.hit = (st != SI);
                   e.op  = (st == SI) ? 2 : ((st == SS || st == SO) ? 3 : 0);
                   e.nx  = SM;
               end
            2: if (st != SI) begin
                   e.sh = 1;
                   if (st == SM) begin
                       e.fl = 1;
                       if (m == 2) e.nx = SO;
                       else begin e.mu = 1; e.nx = SS; end
                   end else if (st == SO) e.fl = 1;
                   else if (st == SE) begin e.fo = 1; e.nx = SS; end
               end
            3: if (st != SI) begin
                   e.fl = (st == SM || st == SO);
                   e.fo = (st == SE);
                   e.nx = SI;
               end
            default: if (st != SI) e.nx = SI;
        endcase
        return e;
    endfunction

    function automatic string req_of(input int kind, input int st);
        if (kind == 0) return (st == SI) ? "R2" : "R3";
        if (kind == 1) return "R4";
        if (st == SI) return "R9";
        if (kind == 2) return (st == SM) ? "R5" : "R6";
        if (kind == 3) return "R7";
        return "R8";
    endfunction

    // bring line at addr to target state; returns the state the requirements predict
    task automatic setup(input int m, input int t, input int addr, output int reached);
        exp_t e;
        int st;
        do_op(m, 4, 1'b0, addr);
        st = SI;
        case (t)
            SS: begin do_op(m, 0, 1'b1, addr); e = model(m, st, 0, 1'b1); st = e.nx; end
            SE: begin do_op(m, 0, 1'b0, addr); e = model(m, st, 0, 1'b0); st = e.nx; end
            SM: begin do_op(m, 1, 1'b0, addr); e = model(m, st, 1, 1'b0); st = e.nx; end
            SO: begin
                do_op(m, 1, 1'b0, addr); e = model(m, st, 1, 1'b0); st = e.nx;
                do_op(m, 2, 1'b0, addr); e = model(m, st, 2, 1'b0); st = e.nx;
            end
            default: st = SI;
        endcase
        reached = st;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int st, reached;
        exp_t e;
        string r;
        for (int m = 0; m < NM; m++) begin
            cpu_valid[m] = 0; cpu_write[m] = 0; cpu_addr[m] = 0; shared_in[m] = 0;
            snoop_valid[m] = 0; snoop_op[m] = 0; snoop_addr[m] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: all lines invalid after reset
        for (int m = 0; m < NM; m++)
            for (int a = 0; a < 16; a++) begin
                probe(m, a, st);
                chk("R1", "reset state", st, SI);
            end

        // sweep: every mode, reachable start state, operation and shared value
        for (int m = 0; m < NM; m++)
            for (int t = 0; t < 5; t++)
                for (int kind = 0; kind < 5; kind++)
                    for (int sh = 0; sh < 2; sh++) begin
                        setup(m, t, 9, reached);
                        if (reached != t) continue;
                        probe(m, 9, st);
                        chk("R2", "setup state", st, t);
                        e = model(m, t, kind, sh[0]);
                        r = req_of(kind, t);
                        do_op(m, kind, sh[0], 9);
                        if (kind < 2) begin
                            chk(r, "bus_op", g_op, e.op);
                            chk(r, "hit", g_hit, e.hit);
                            chk("R11", "no wb on same tag", g_wb, 0);
                        end else begin
                            chk(r, "flush", g_fl, e.fl);
                            chk(r, "flush_opt", g_fo, e.fo);
                            chk(r, "mem_update", g_mu, e.mu);
                            chk((kind == 2) ? "R10" : r, "shared_out", g_sh, e.sh);
                        end
                        probe(m, 9, st);
                        chk(r, "next state", st, e.nx);
                        chk("R13", "state legal for mode",
                            int'(!((m != 2 && st == SO) || (m == 0 && st == SE))), 1);
                    end

        // R11: dirty victims write back, clean victims do not (five-state mode)
        setup(2, SM, 1, reached);
        do_op(2, 0, 1'b0, 5);
        chk("R11", "wb from M victim", g_wb, 1);
        chk("R11", "wb tag", g_wbt, 0);
        chk("R11", "miss op", g_op, 1);
        probe(2, 5, st);  chk("R11", "new line", st, SE);
        probe(2, 1, st);  chk("R11", "old line gone", st, SI);
        do_op(2, 0, 1'b1, 13);
        chk("R11", "no wb from E victim", g_wb, 0);
        do_op(2, 0, 1'b0, 9);
        chk("R11", "no wb from S victim", g_wb, 0);
        setup(2, SO, 2, reached);
        do_op(2, 1, 1'b0, 14);
        chk("R11", "wb from O victim", g_wb, 1);
        chk("R11", "wb tag O", g_wbt, 0);
        chk("R11", "write miss op", g_op, 2);
        do_op(2, 0, 1'b0, 6);
        chk("R11", "wb from M victim tag 3", g_wb, 1);
        chk("R11", "wb tag 3", g_wbt, 3);

        // R9: snoop to a different tag on a resident index is ignored
        for (int m = 0; m < NM; m++) begin
            setup(m, SM, 3, reached);
            for (int k = 2; k < 5; k++) begin
                do_op(m, k, 1'b0, 7);
                chk("R9", "mismatch flush", g_fl, 0);
                chk("R9", "mismatch flush_opt", g_fo, 0);
                chk("R9", "mismatch shared", g_sh, 0);
                chk("R9", "mismatch mem_update", g_mu, 0);
                probe(m, 3, st);
                chk("R9", "resident unchanged", st, SM);
            end
        end

        // R12: a snoop in the same cycle blocks a processor write
        for (int m = 0; m < NM; m++) begin
            do_op(m, 4, 1'b0, 11);
            drive(m, 1'b1, 1'b1, 11, 1'b0, 1'b1, 1, 15);
            chk("R12", "cpu_ready", g_ready, 0);
            chk("R12", "bus_op", g_op, 0);
            chk("R12", "hit", g_hit, 0);
            probe(m, 11, st);
            chk("R12", "write not applied", st, SI);
            drive(m, 1'b1, 1'b1, 11, 1'b0, 1'b0, 0, 0);
            chk("R12", "cpu_ready idle bus", g_ready, 1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule